// File: doc/BRIEF.md
# DMA Transfer Request Queue

This block is the software-facing front end of a single-channel DMA engine. Software stages a transfer description through a small word-indexed register bus: destination and source addresses, a row length, a row count, destination and source strides, and three flag bits. A write of 1 to the start register takes the staged description, tags it with a 5-bit transfer number and places it in a four-entry queue. Software can read the number the next request will get before it submits, and later match completions against it.

Queued requests leave in submission order through a valid/ready request port towards the data movers, which are outside this block. The request port obeys these back-pressure rules: once `req_valid` is high it stays high, with every payload field unchanged, until a cycle where `req_ready` is also high. Only a flush may withdraw it. A pause stops new offers but never withdraws one already made. The data movers report each finished request with a one-cycle `cpl_valid` pulse carrying its number. That pulse sets the matching bit of a done bitmap. Two pending interrupt causes, each with a mask bit, drive one level interrupt line. One cause is raised when a queued request is handed off and a slot frees. The other is raised when a request completes.

Top module: `xfer_req_queue`

## Requirements
- R1: After reset the mask register (index 11) reads 3, the pending register (index 12) reads 0, the next-number register (index 1) reads 0, the start register (index 2) reads 0, the done register (index 10) reads 0, and `req_valid` and `irq` are low.
- R2: A write with bit 0 set to the start register (index 2), while the engine is enabled and the queue has a free slot, queues the staged fields tagged with the current next number; that number then advances by one modulo 32.
- R3: The queue holds 4 requests; while it is full the start register reads 1, otherwise 0, and a start write while full queues nothing and leaves the next number unchanged.
- R4: While the queue is full, writes to the staging registers (indices 3 to 9) are ignored: the read-back and the next submitted request keep the earlier values.
- R5: Requests are offered in submission order; an offer stays valid with a stable payload until accepted; new offers start only when control bit 0 (enable) is 1 and control bit 1 (pause) is 0.
- R6: A write to the control register (index 0) with bit 0 clear empties the queue and drops `req_valid` in the next cycle; start writes while disabled are ignored.
- R7: A completion pulse with number n sets bit n of the done register; a read of the done register returns its bits and clears exactly those, so a completion in the same cycle as the read survives.
- R8: Pending bit 0 is set on each request handshake and pending bit 1 on each completion; writing 1 to a pending bit clears it, and a new event in the same cycle wins.
- R9: `irq` is high when any pending bit has a clear mask bit; a mask bit of 1 hides its cause.
- R10: The flags register (index 3) keeps bit 0 as cyclic, bit 1 as last and bit 2 as partial-report enable, reads back those three bits and passes them unchanged on `req_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata one cycle later |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| req_valid | output | 1 | Request offered downstream |
| req_ready | input | 1 | Downstream accepts the request |
| req_id | output | 5 | Transfer number of the offered request |
| req_flags | output | 3 | Cyclic, last, partial-report flags |
| req_dst | output | 32 | Destination address |
| req_src | output | 32 | Source address |
| req_xlen | output | 24 | Row length |
| req_ylen | output | 24 | Row count |
| req_dst_stride | output | 24 | Destination stride |
| req_src_stride | output | 24 | Source stride |
| cpl_valid | input | 1 | Completion pulse |
| cpl_id | input | 5 | Number of the completed request |
| irq | output | 1 | Interrupt line |

## Verification
On every cycle the assertions check several cycle-local rules. The queue never overflows or underflows. A stalled offer keeps its payload. A flush empties the request port. Every accepted submit advances the number by one, and a submit against a full queue leaves it alone. A completion always lands in the done bitmap, and a pending event always lands in its bit. The other behaviours show only in the bench's scenarios: payloads leave in submission order with the fields as staged, staging writes are really ignored while full, the number wraps after 32 submits, a read clears the done bits while a same-cycle completion survives, and the mask acts on the interrupt line.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int ID_W    = 5;
  localparam int NUM_IDS = 1 << ID_W;
  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 24;
  localparam int FLAG_W  = 3;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = 4;
  localparam int IRQ_N   = 2;

  localparam logic [IDX_W-1:0] RI_CTRL  = 4'd0;
  localparam logic [IDX_W-1:0] RI_NEXT  = 4'd1;
  localparam logic [IDX_W-1:0] RI_START = 4'd2;
  localparam logic [IDX_W-1:0] RI_FLAGS = 4'd3;
  localparam logic [IDX_W-1:0] RI_DST   = 4'd4;
  localparam logic [IDX_W-1:0] RI_SRC   = 4'd5;
  localparam logic [IDX_W-1:0] RI_XLEN  = 4'd6;
  localparam logic [IDX_W-1:0] RI_YLEN  = 4'd7;
  localparam logic [IDX_W-1:0] RI_DSTR  = 4'd8;
  localparam logic [IDX_W-1:0] RI_SSTR  = 4'd9;
  localparam logic [IDX_W-1:0] RI_DONE  = 4'd10;
  localparam logic [IDX_W-1:0] RI_MASK  = 4'd11;
  localparam logic [IDX_W-1:0] RI_PEND  = 4'd12;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [FLAG_W-1:0] flags;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
    logic [LEN_W-1:0]  xlen;
    logic [LEN_W-1:0]  ylen;
    logic [LEN_W-1:0]  dst_stride;
    logic [LEN_W-1:0]  src_stride;
  } xfer_req_t;
endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo #(
  parameter int  DEPTH = 4,
  parameter type T     = logic [7:0]
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic push,
  input  T     din,
  input  logic pop,
  output T     dout,
  output logic empty,
  output logic full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  T               slots [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign dout  = slots[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  // R3: the queue never takes an entry beyond its depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/dmaq_done.sv
module dmaq_done #(
  parameter int IDW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpl_valid,
  input  logic [IDW-1:0]    cpl_id,
  input  logic              rd_clr,
  output logic [(1<<IDW)-1:0] bits
);
  localparam int N = 1 << IDW;

  logic [N-1:0] set_vec;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign set_vec[g] = cpl_valid && (cpl_id == IDW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bits <= '0;
    else if (rd_clr) bits <= set_vec;
    else             bits <= bits | set_vec;
  end

  // R7: a completion always shows in the bitmap next cycle
  a_r7_cpl_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> bits[$past(cpl_id)]);
  // R7: a read with no completion leaves the bitmap empty
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && !cpl_valid |=> bits == '0);
endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_bits,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_bits,
  output logic [N-1:0] pend,
  output logic [N-1:0] mask,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_cause
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        mask[i] <= 1'b1;
      end else begin
        pend[i] <= set[i] | (pend[i] & ~(clr_wr & clr_bits[i]));
        if (mask_wr) mask[i] <= mask_bits[i];
      end
    end

    // R8: an event is never lost, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> pend[i]);
    // R8: write-one-to-clear without a new event empties the bit
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr && clr_bits[i] && !set[i] |=> !pend[i]);
  end

  assign irq = |(pend & ~mask);
endmodule

// File: rtl/xfer_req_queue.sv
module xfer_req_queue
  import dmaq_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ID_W-1:0]   req_id,
  output logic [FLAG_W-1:0] req_flags,
  output logic [ADDR_W-1:0] req_dst,
  output logic [ADDR_W-1:0] req_src,
  output logic [LEN_W-1:0]  req_xlen,
  output logic [LEN_W-1:0]  req_ylen,
  output logic [LEN_W-1:0]  req_dst_stride,
  output logic [LEN_W-1:0]  req_src_stride,
  input  logic              cpl_valid,
  input  logic [ID_W-1:0]   cpl_id,
  output logic              irq
);
  logic            run_en, run_pause;
  logic [ID_W-1:0] next_id;
  xfer_req_t       stg, push_data, head;
  logic            q_empty, q_full, held;
  logic            flush, start_wr, submit, pop;
  logic [NUM_IDS-1:0] done_bits;
  logic [IRQ_N-1:0]   pend, mask;
  logic [DATA_W-1:0]  rd_mux;

  function automatic logic hit(input logic [IDX_W-1:0] i);
    return reg_wr && (reg_idx == i);
  endfunction

  assign flush    = hit(RI_CTRL) && !reg_wdata[0];
  assign start_wr = hit(RI_START) && reg_wdata[0];
  assign submit   = start_wr && run_en && !q_full;
  assign pop      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en    <= 1'b0;
      run_pause <= 1'b0;
      next_id   <= '0;
      held      <= 1'b0;
    end else begin
      if (hit(RI_CTRL)) begin
        run_en    <= reg_wdata[0];
        run_pause <= reg_wdata[1];
      end
      if (submit) next_id <= next_id + ID_W'(1);
      held <= !flush && req_valid && !req_ready;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= '0;
    end else if (reg_wr && !q_full) begin
      case (reg_idx)
        RI_FLAGS: stg.flags      <= reg_wdata[FLAG_W-1:0];
        RI_DST:   stg.dst        <= reg_wdata[ADDR_W-1:0];
        RI_SRC:   stg.src        <= reg_wdata[ADDR_W-1:0];
        RI_XLEN:  stg.xlen       <= reg_wdata[LEN_W-1:0];
        RI_YLEN:  stg.ylen       <= reg_wdata[LEN_W-1:0];
        RI_DSTR:  stg.dst_stride <= reg_wdata[LEN_W-1:0];
        RI_SSTR:  stg.src_stride <= reg_wdata[LEN_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    push_data    = stg;
    push_data.id = next_id;
  end

  dmaq_fifo #(.DEPTH(QDEPTH), .T(xfer_req_t)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (submit),
    .din   (push_data),
    .pop   (pop),
    .dout  (head),
    .empty (q_empty),
    .full  (q_full)
  );

  assign req_valid      = !q_empty && ((run_en && !run_pause) || held);
  assign req_id         = head.id;
  assign req_flags      = head.flags;
  assign req_dst        = head.dst;
  assign req_src        = head.src;
  assign req_xlen       = head.xlen;
  assign req_ylen       = head.ylen;
  assign req_dst_stride = head.dst_stride;
  assign req_src_stride = head.src_stride;

  dmaq_done #(.IDW(ID_W)) u_done (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpl_valid (cpl_valid),
    .cpl_id    (cpl_id),
    .rd_clr    (reg_rd && (reg_idx == RI_DONE)),
    .bits      (done_bits)
  );

  dmaq_irq #(.N(IRQ_N)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       ({cpl_valid, pop}),
    .clr_wr    (hit(RI_PEND)),
    .clr_bits  (reg_wdata[IRQ_N-1:0]),
    .mask_wr   (hit(RI_MASK)),
    .mask_bits (reg_wdata[IRQ_N-1:0]),
    .pend      (pend),
    .mask      (mask),
    .irq       (irq)
  );

  always_comb begin
    case (reg_idx)
      RI_CTRL:  rd_mux = DATA_W'({run_pause, run_en});
      RI_NEXT:  rd_mux = DATA_W'(next_id);
      RI_START: rd_mux = DATA_W'(q_full);
      RI_FLAGS: rd_mux = DATA_W'(stg.flags);
      RI_DST:   rd_mux = DATA_W'(stg.dst);
      RI_SRC:   rd_mux = DATA_W'(stg.src);
      RI_XLEN:  rd_mux = DATA_W'(stg.xlen);
      RI_YLEN:  rd_mux = DATA_W'(stg.ylen);
      RI_DSTR:  rd_mux = DATA_W'(stg.dst_stride);
      RI_SSTR:  rd_mux = DATA_W'(stg.src_stride);
      RI_DONE:  rd_mux = DATA_W'(done_bits);
      RI_MASK:  rd_mux = DATA_W'(mask);
      RI_PEND:  rd_mux = DATA_W'(pend);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R5: a stalled offer keeps valid and payload until accepted
  a_r5_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !flush |=> req_valid && $stable(head));
  // R2: every accepted submit advances the number by one
  a_r2_id_advance: assert property (@(posedge clk) disable iff (!rst_n)
    submit |=> next_id == $past(next_id) + ID_W'(1));
  // R3: a start write against a full queue changes nothing
  a_r3_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && q_full |=> $stable(next_id));
  // R6: a flush leaves nothing on the request port
  a_r6_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !req_valid);
endmodule

// File: tb/xfer_req_queue_tb_top.sv
module xfer_req_queue_tb_top;
  localparam int QD = 4;
  localparam int PL = 168;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [4:0]  req_id;
  logic [2:0]  req_flags;
  logic [31:0] req_dst, req_src;
  logic [23:0] req_xlen, req_ylen, req_dst_stride, req_src_stride;
  logic        cpl_valid = 1'b0;
  logic [4:0]  cpl_id = '0;
  logic        irq;

  always #4 clk = ~clk;

  xfer_req_queue dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
    .req_flags(req_flags), .req_dst(req_dst), .req_src(req_src),
    .req_xlen(req_xlen), .req_ylen(req_ylen),
    .req_dst_stride(req_dst_stride), .req_src_stride(req_src_stride),
    .cpl_valid(cpl_valid), .cpl_id(cpl_id), .irq(irq)
  );

  logic [PL-1:0] pay;
  assign pay = {req_id, req_flags, req_dst, req_src, req_xlen, req_ylen,
                req_dst_stride, req_src_stride};

  int checks = 0, fails = 0;
  logic [PL-1:0] mq[$];
  logic [4:0]  nid = '0;
  logic        b_en = 1'b0;
  logic [2:0]  s_flags = '0;
  logic [31:0] s_dst = '0, s_src = '0;
  logic [23:0] s_xlen = '0, s_ylen = '0, s_dstr = '0, s_sstr = '0;
  logic [31:0] dmodel = '0;
  logic [31:0] rv;

  task automatic check(input string tag, input logic [PL-1:0] act, input logic [PL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [PL-1:0] exp_pack(input logic [4:0] id);
    return {id, s_flags, s_dst, s_src, s_xlen, s_ylen, s_dstr, s_sstr};
  endfunction

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_idx = idx;
    @(negedge clk); d = reg_rdata; reg_rd = 1'b0;
  endtask

  task automatic cpl(input logic [4:0] id);
    @(negedge clk); cpl_valid = 1'b1; cpl_id = id;
    @(negedge clk); cpl_valid = 1'b0;
  endtask

  task automatic stage_rand();
    logic [31:0] v [7];
    for (int k = 0; k < 7; k++) begin
      v[k] = $urandom;
      wr(4'(3 + k), v[k]);
    end
    if (mq.size() < QD) begin
      s_flags = v[0][2:0]; s_dst = v[1]; s_src = v[2];
      s_xlen = v[3][23:0]; s_ylen = v[4][23:0];
      s_dstr = v[5][23:0]; s_sstr = v[6][23:0];
    end
  endtask

  task automatic submit();
    wr(4'd2, 32'd1);
    if (b_en && mq.size() < QD) begin
      mq.push_back(exp_pack(nid));
      nid = nid + 5'd1;
    end
  endtask

  task automatic drain(input bit rnd);
    bit stall = 1'b0;
    for (int c = 0; c < 400 && mq.size() > 0; c++) begin
      @(negedge clk);
      if (stall) begin
        check("R5 offer held", PL'(req_valid), PL'(1));
        check("R5 payload stable", pay, mq[0]);
      end
      req_ready = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
      if (req_valid && req_ready) begin
        check("R2 R10 payload order", pay, mq[0]);
        void'(mq.pop_front());
        stall = 1'b0;
      end else begin
        stall = req_valid;
      end
    end
    @(negedge clk); req_ready = 1'b0;
    check("R5 queue emptied", PL'(mq.size()), PL'(0));
    check("R5 no offer after drain", PL'(req_valid), PL'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all-requirements act=timeout exp=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // Reset state
    check("R1 req_valid", PL'(req_valid), PL'(0));
    check("R1 irq", PL'(irq), PL'(0));
    rd(4'd11, rv); check("R1 mask", PL'(rv), PL'(3));
    rd(4'd12, rv); check("R1 pending", PL'(rv), PL'(0));
    rd(4'd1, rv);  check("R1 next number", PL'(rv), PL'(0));
    rd(4'd2, rv);  check("R1 start", PL'(rv), PL'(0));
    rd(4'd10, rv); check("R1 done", PL'(rv), PL'(0));

    // Fill the queue with back-pressure
    wr(4'd0, 32'd1); b_en = 1'b1;
    for (int k = 0; k < QD; k++) begin
      rd(4'd2, rv); check("R3 start not full", PL'(rv), PL'(0));
      stage_rand(); submit();
    end
    rd(4'd2, rv); check("R3 start reads full", PL'(rv), PL'(1));
    rd(4'd1, rv); check("R2 next number", PL'(rv), PL'(nid));
    check("R5 offer while enabled", PL'(req_valid), PL'(1));
    submit();
    rd(4'd1, rv); check("R3 submit while full ignored", PL'(rv), PL'(nid));
    stage_rand();
    rd(4'd3, rv); check("R4 R10 flags kept while full", PL'(rv), PL'(s_flags));
    rd(4'd6, rv); check("R4 length kept while full", PL'(rv), PL'(s_xlen));
    drain(1'b1);
    submit();
    drain(1'b0);
    rd(4'd12, rv); check("R8 start-of-transfer pending", PL'(rv[0]), PL'(1));
    wr(4'd12, 32'd1);
    rd(4'd12, rv); check("R8 pending cleared", PL'(rv), PL'(0));

    // Pause holds new offers back
    wr(4'd0, 32'd3);
    stage_rand(); submit();
    repeat (5) @(negedge clk);
    check("R5 no offer while paused", PL'(req_valid), PL'(0));
    wr(4'd0, 32'd1);
    drain(1'b1);

    // Flush
    stage_rand(); submit(); stage_rand(); submit();
    wr(4'd0, 32'd0); b_en = 1'b0; mq.delete();
    check("R6 flush drops offer", PL'(req_valid), PL'(0));
    rd(4'd2, rv); check("R6 queue empty after flush", PL'(rv), PL'(0));
    submit();
    rd(4'd1, rv); check("R6 submit while disabled ignored", PL'(rv), PL'(nid));
    wr(4'd0, 32'd1); b_en = 1'b1;
    check("R6 nothing left after re-enable", PL'(req_valid), PL'(0));

    // Completion bitmap
    cpl(5'd5); cpl(5'd31);
    rd(4'd10, rv); check("R7 done bits", PL'(rv), PL'(32'h8000_0020));
    rd(4'd10, rv); check("R7 cleared by read", PL'(rv), PL'(0));
    cpl(5'd3);
    @(negedge clk); reg_rd = 1'b1; reg_idx = 4'd10; cpl_valid = 1'b1; cpl_id = 5'd9;
    @(negedge clk); rv = reg_rdata; reg_rd = 1'b0; cpl_valid = 1'b0;
    check("R7 read returns old bits", PL'(rv), PL'(32'h8));
    rd(4'd10, rv); check("R7 same-cycle completion survives", PL'(rv), PL'(32'h200));
    dmodel = '0;
    for (int k = 0; k < 20; k++) begin
      logic [4:0] id = 5'($urandom);
      cpl(id); dmodel[id] = 1'b1;
    end
    rd(4'd10, rv); check("R7 random completions", PL'(rv), PL'(dmodel));

    // Interrupt masking
    wr(4'd12, 32'd3);
    rd(4'd12, rv); check("R8 both cleared", PL'(rv), PL'(0));
    cpl(5'd7);
    @(negedge clk); check("R9 masked completion", PL'(irq), PL'(0));
    wr(4'd11, 32'd1);
    check("R9 unmasked completion", PL'(irq), PL'(1));
    wr(4'd12, 32'd2);
    check("R8 clear drops line", PL'(irq), PL'(0));
    stage_rand(); submit(); drain(1'b0);
    rd(4'd12, rv); check("R8 handshake pending", PL'(rv), PL'(1));
    check("R9 start cause masked", PL'(irq), PL'(0));
    wr(4'd11, 32'd0);
    check("R9 start cause unmasked", PL'(irq), PL'(1));
    wr(4'd12, 32'd1);
    check("R8 start cause cleared", PL'(irq), PL'(0));

    // Number wrap
    for (int k = 0; k < 33; k++) begin
      stage_rand(); submit(); drain(1'b1);
    end
    rd(4'd1, rv); check("R2 number wraps modulo 32", PL'(rv), PL'(nid));
    rd(4'd3, rv); check("R10 flags read-back", PL'(rv), PL'(s_flags));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule